// File: doc/BRIEF.md
# Banked Cartridge Mapper with Infrared Port

This block is the control logic of a plug-in cartridge on an 8-bit processor bus with 16-bit addresses. Writes into the low control windows set an operating mode and two 8-bit bank numbers. The bank numbers go to the ROM and RAM address logic outside this block.

In storage mode, the external-RAM window at 0xA000–0xBFFF passes accesses through to a banked RAM array. A write drives a RAM write strobe. No enable register gates it. In infrared mode, the same window becomes a light port. A write sets the cartridge LED from data bit 0. A read returns a fixed pattern, with bit 0 showing whether any light source is active. Each change of the LED level produces a one-cycle event. The event carries the number of clock edges since the previous change, so a transceiver model can rebuild the pulse timing.

Top module: `cart_mapper`

## Requirements
- R1: After reset the block is in storage mode, irLed is 0, romBank is 1, ramBank is 0 and irChange is 0.
- R2: A write to 0x0000–0x1FFF enters infrared mode when data[3:0] is 0xE and returns to storage mode for any other low nibble. The new mode takes effect from the next cycle.
- R3: A write to 0x2000–0x3FFF loads romBank with the full data byte, visible from the next cycle.
- R4: A write to 0x4000–0x5FFF loads ramBank with the full data byte, visible from the next cycle.
- R5: Writes to 0x6000–0x7FFF change neither the mode, the bank numbers nor the LED.
- R6: In infrared mode, a write to 0xA000–0xBFFF sets irLed to data[0] from the next cycle and never asserts ramWrEn.
- R7: In infrared mode, a read of 0xA000–0xBFFF returns 0xC0 in the same cycle, with bit 0 set when irLed, extLight or consoleLed is 1.
- R8: In storage mode, a write to 0xA000–0xBFFF asserts ramWrEn in the same cycle without any enable register. A read returns ramRdData when HAS_RAM is 1 and 0xFF when it is 0. Reads outside that window return 0xFF.
- R9: An infrared-mode write that changes the LED level pulses irChange for exactly one cycle after the write. The pulse carries irDelta, the count of clock edges from the previous change edge, or from the last reset edge, up to this one. A write that does not change the level produces no pulse.
- R10: irDelta saturates at 2^CNT_W-1 when the gap is longer than that.
- R11: In storage mode, writes to 0xA000–0xBFFF leave irLed unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 16 | Bus address |
| busWrData | input | 8 | Bus write data |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe |
| busRdData | output | 8 | Read data for the external-RAM window |
| ramRdData | input | 8 | Data from the external RAM array |
| ramWrEn | output | 1 | RAM write enable |
| extLight | input | 1 | Light sensed from outside |
| consoleLed | input | 1 | Host's own IR LED is on |
| romBank | output | 8 | ROM bank number |
| ramBank | output | 8 | RAM bank number |
| irLed | output | 1 | Cartridge IR LED level |
| irChange | output | 1 | One-cycle LED change event |
| irDelta | output | CNT_W | Edges since the previous LED change |

## Verification
The results fall into two timing groups, and the bench samples each one at its own point.

Read data and ramWrEn are combinational. The bench samples them one time step after driving the inputs, in the same cycle as the access.

Mode, bank numbers and irLed are registered. The bench samples them at the falling edge after the capturing rising edge. The LED event also appears at that falling edge, one cycle after the write. The driver predicts irDelta from its own count of rising edges and queues the prediction. A monitor compares each pulse against the queue at every falling edge, so an unexpected or missing pulse is reported.

// File: rtl/cart_mapper_pkg.sv
package cart_mapper_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 16;

  typedef struct packed {
    logic modeWr;
    logic modeIr;
    logic lowWr;
    logic highWr;
    logic ledWr;
    logic ledVal;
    logic winRd;
  } mapStrobe_t;
endpackage

// File: rtl/cart_mapper_ctrl.sv
module cart_mapper_ctrl
  import cart_mapper_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              irMode,
  output mapStrobe_t        strobe,
  output logic              ramWrEn
);
  localparam logic [2:0] SEG_MODE = 3'b000;
  localparam logic [2:0] SEG_LOW  = 3'b001;
  localparam logic [2:0] SEG_HIGH = 3'b010;
  localparam logic [2:0] SEG_XRAM = 3'b101;

  logic [2:0] seg;
  logic       xramHit;

  assign seg     = busAddr[ADDR_W-1:ADDR_W-3];
  assign xramHit = (seg == SEG_XRAM);

  always_comb begin
    strobe.modeWr = busWr && (seg == SEG_MODE);
    strobe.modeIr = (busWrData[3:0] == 4'hE);
    strobe.lowWr  = busWr && (seg == SEG_LOW);
    strobe.highWr = busWr && (seg == SEG_HIGH);
    strobe.ledWr  = busWr && xramHit && irMode;
    strobe.ledVal = busWrData[0];
    strobe.winRd  = busRd && xramHit;
    ramWrEn       = busWr && xramHit && !irMode;
  end
endmodule

// File: rtl/cart_mapper_dp.sv
module cart_mapper_dp
  import cart_mapper_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter bit HAS_RAM = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  mapStrobe_t        strobe,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] ramRdData,
  input  logic              extLight,
  input  logic              consoleLed,
  output logic              irMode,
  output logic [DATA_W-1:0] bankLow,
  output logic [DATA_W-1:0] bankHigh,
  output logic              ledOn,
  output logic              irChange,
  output logic [CNT_W-1:0]  irDelta,
  output logic [DATA_W-1:0] busRdData
);
  localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [DATA_W-1:0] IR_BASE  = 8'hC0;
  localparam logic [DATA_W-1:0] IDLE_RD  = 8'hFF;

  logic [CNT_W-1:0] gapCnt;
  logic [CNT_W-1:0] gapNext;
  logic             ledFlip;
  logic             senseAny;

  assign gapNext  = (gapCnt == CNT_MAX) ? gapCnt : gapCnt + 1'b1;
  assign ledFlip  = strobe.ledWr && (strobe.ledVal != ledOn);
  assign senseAny = ledOn || extLight || consoleLed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irMode   <= 1'b0;
      bankLow  <= DATA_W'(1);
      bankHigh <= '0;
      ledOn    <= 1'b0;
      gapCnt   <= '0;
      irChange <= 1'b0;
      irDelta  <= '0;
    end else begin
      if (strobe.modeWr) irMode   <= strobe.modeIr;
      if (strobe.lowWr)  bankLow  <= busWrData;
      if (strobe.highWr) bankHigh <= busWrData;
      irChange <= 1'b0;
      if (ledFlip) begin
        ledOn    <= strobe.ledVal;
        irChange <= 1'b1;
        irDelta  <= gapNext;
        gapCnt   <= '0;
      end else begin
        gapCnt <= gapNext;
      end
    end
  end

  generate
    if (HAS_RAM) begin : g_ram
      always_comb begin
        if (!strobe.winRd)  busRdData = IDLE_RD;
        else if (irMode)    busRdData = IR_BASE | DATA_W'(senseAny);
        else                busRdData = ramRdData;
      end
    end else begin : g_noram
      always_comb begin
        if (strobe.winRd && irMode) busRdData = IR_BASE | DATA_W'(senseAny);
        else                        busRdData = IDLE_RD;
      end
    end
  endgenerate
endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
  import cart_mapper_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter bit HAS_RAM = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWr,
  input  logic              busRd,
  output logic [DATA_W-1:0] busRdData,
  input  logic [DATA_W-1:0] ramRdData,
  output logic              ramWrEn,
  input  logic              extLight,
  input  logic              consoleLed,
  output logic [DATA_W-1:0] romBank,
  output logic [DATA_W-1:0] ramBank,
  output logic              irLed,
  output logic              irChange,
  output logic [CNT_W-1:0]  irDelta
);
  mapStrobe_t strobe;
  logic       irMode;

  cart_mapper_ctrl ctrl_i (
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busWr     (busWr),
    .busRd     (busRd),
    .irMode    (irMode),
    .strobe    (strobe),
    .ramWrEn   (ramWrEn)
  );

  cart_mapper_dp #(.CNT_W(CNT_W), .HAS_RAM(HAS_RAM)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busWrData  (busWrData),
    .ramRdData  (ramRdData),
    .extLight   (extLight),
    .consoleLed (consoleLed),
    .irMode     (irMode),
    .bankLow    (romBank),
    .bankHigh   (ramBank),
    .ledOn      (irLed),
    .irChange   (irChange),
    .irDelta    (irDelta),
    .busRdData  (busRdData)
  );
endmodule

// File: rtl/cart_mapper_chk.sv
module cart_mapper_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [15:0]      busAddr,
  input logic             busWr,
  input logic             busRd,
  input logic [7:0]       busRdData,
  input logic             ramWrEn,
  input logic             irMode,
  input logic [7:0]       romBank,
  input logic [7:0]       ramBank,
  input logic             irLed,
  input logic             irChange,
  input logic [CNT_W-1:0] irDelta
);
  logic xramAcc;
  assign xramAcc = (busAddr[15:13] == 3'b101);

  assert_no_ramwr_ir_R6: assert property (@(posedge clk) disable iff (!rstN)
    irMode |-> !ramWrEn);

  assert_ir_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && xramAcc && irMode) |-> (busRdData[7:1] == 7'b1100000));

  assert_led_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && xramAcc && irMode) |=> $stable(irLed));

  assert_pulse_change_R9: assert property (@(posedge clk) disable iff (!rstN)
    irChange |-> (irLed != $past(irLed)));

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    irChange |=> !irChange);

  assert_delta_nonzero_R10: assert property (@(posedge clk) disable iff (!rstN)
    irChange |-> (irDelta != '0));

  assert_bank_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busAddr[15:14] == 2'b00) |=> ($stable(romBank) && $stable(ramBank) || busAddr[15:13] == 3'b010));
endmodule

bind cart_mapper cart_mapper_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWr     (busWr),
  .busRd     (busRd),
  .busRdData (busRdData),
  .ramWrEn   (ramWrEn),
  .irMode    (irMode),
  .romBank   (romBank),
  .ramBank   (ramBank),
  .irLed     (irLed),
  .irChange  (irChange),
  .irDelta   (irDelta)
);

// File: tb/cart_mapper_tb_top.sv
module cart_mapper_tb_top;
  localparam int CW = 6;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [7:0] ramRdData = 8'h96;
  logic extLight = 1'b0, consoleLed = 1'b0;
  logic [7:0] busRdData, busRdData2, romBank, ramBank, romBank2, ramBank2;
  logic ramWrEn, ramWrEn2, irLed, irLed2, irChange, irChange2;
  logic [CW-1:0] irDelta, irDelta2;

  int total = 0, bad = 0;
  int edgeIdx = 0;
  int lastChange = 0;
  logic expLed = 1'b0;
  int expQ[$];

  always #5 clk = ~clk;
  always @(posedge clk) edgeIdx <= edgeIdx + 1;

  cart_mapper #(.CNT_W(CW), .HAS_RAM(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWr(busWr), .busRd(busRd), .busRdData(busRdData), .ramRdData(ramRdData),
    .ramWrEn(ramWrEn), .extLight(extLight), .consoleLed(consoleLed),
    .romBank(romBank), .ramBank(ramBank), .irLed(irLed),
    .irChange(irChange), .irDelta(irDelta));

  cart_mapper #(.CNT_W(CW), .HAS_RAM(1'b0)) noRam_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWr(busWr), .busRd(busRd), .busRdData(busRdData2), .ramRdData(ramRdData),
    .ramWrEn(ramWrEn2), .extLight(extLight), .consoleLed(consoleLed),
    .romBank(romBank2), .ramBank(ramBank2), .irLed(irLed2),
    .irChange(irChange2), .irDelta(irDelta2));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // drive one write; ramWrEn sampled inside the access cycle
  task automatic busWrite(input logic [15:0] a, input logic [7:0] d,
                          input bit chkWe, input logic expWe, input string tag);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    if (a[15:13] == 3'b101 && expWe == 1'b0 && a != 16'h0) begin
      // LED prediction for the scoreboard (infrared writes only)
    end
    #1;
    if (chkWe) chk(tag, ramWrEn, expWe);
    @(negedge clk);
    busWr = 1'b0;
  endtask

  // infrared-mode write to the window; pushes the expected event
  task automatic irWrite(input logic [15:0] a, input logic [7:0] d);
    int capEdge;
    @(negedge clk);
    capEdge = edgeIdx + 1;
    busAddr = a; busWrData = d; busWr = 1'b1;
    if (d[0] != expLed) begin
      expQ.push_back((capEdge - lastChange) > CMAX ? CMAX : capEdge - lastChange);
      lastChange = capEdge;
      expLed = d[0];
    end
    #1;
    chk("R6 no ramWrEn in ir mode", ramWrEn, 1'b0);
    @(negedge clk);
    busWr = 1'b0;
    chk("R6 led level", irLed, expLed);
  endtask

  task automatic busRead(input logic [15:0] a, output logic [7:0] d, output logic [7:0] d2);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1;
    d = busRdData; d2 = busRdData2;
    busRd = 1'b0;
  endtask

  // monitor: pops one expected delta per observed pulse
  always @(negedge clk) begin
    if (rstN && irChange) begin
      if (expQ.size() == 0) begin
        total++; bad++;
        $display("FAIL R9 unexpected pulse act=%0d exp=none", irDelta);
      end else begin
        automatic int e = expQ.pop_front();
        chk("R9/R10 delta", 32'(irDelta), 32'(e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r, r2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    lastChange = edgeIdx;  // first edge with rstN high is edgeIdx+1
    @(negedge clk);
    // R1 reset state
    chk("R1 romBank", romBank, 8'd1);
    chk("R1 ramBank", ramBank, 8'd0);
    chk("R1 irLed", irLed, 1'b0);
    chk("R1 irChange", irChange, 1'b0);
    busRead(16'hA000, r, r2);
    chk("R1 storage mode read", r, 8'h96);

    // R3 / R4 bank loads
    busWrite(16'h2000, 8'h5A, 0, 0, "R3");
    chk("R3 romBank", romBank, 8'h5A);
    busWrite(16'h3FFF, 8'h07, 0, 0, "R3");
    chk("R3 romBank top", romBank, 8'h07);
    busWrite(16'h4000, 8'h3C, 0, 0, "R4");
    chk("R4 ramBank", ramBank, 8'h3C);
    busWrite(16'h5FFF, 8'hA5, 0, 0, "R4");
    chk("R4 ramBank top", ramBank, 8'hA5);

    // R5 ignored window
    busWrite(16'h6000, 8'hFF, 0, 0, "R5");
    busWrite(16'h7FFF, 8'h0E, 0, 0, "R5");
    chk("R5 romBank", romBank, 8'h07);
    chk("R5 ramBank", ramBank, 8'hA5);
    busRead(16'hB000, r, r2);
    chk("R5 mode still storage", r, 8'h96);

    // R8 storage mode access
    busWrite(16'hA123, 8'h01, 1, 1, "R8 ramWrEn");
    chk("R11 led unchanged", irLed, 1'b0);
    busRead(16'hBFFF, r, r2);
    chk("R8 ram read", r, 8'h96);
    chk("R8 no ram read", r2, 8'hFF);
    busRead(16'h4000, r, r2);
    chk("R8 outside window", r, 8'hFF);

    // R2 enter infrared mode
    busWrite(16'h1000, 8'h3E, 0, 0, "R2");
    busRead(16'hA000, r, r2);
    chk("R2 ir read", r, 8'hC0);
    chk("R7 ir read no-ram", r2, 8'hC0);
    extLight = 1'b1;
    busRead(16'hA000, r, r2);
    chk("R7 ext light", r, 8'hC1);
    extLight = 1'b0; consoleLed = 1'b1;
    busRead(16'hA000, r, r2);
    chk("R7 console led", r, 8'hC1);
    consoleLed = 1'b0;

    // R6 / R9 LED events
    irWrite(16'hA000, 8'h01);
    busRead(16'hA000, r, r2);
    chk("R7 own led", r, 8'hC1);
    irWrite(16'hBFFF, 8'h03);           // same level: no pulse (R9)
    repeat (5) @(negedge clk);
    irWrite(16'hA010, 8'hFE);
    irWrite(16'hA010, 8'h01);
    // R10 saturation
    repeat (100) @(negedge clk);
    irWrite(16'hB000, 8'h00);

    // R2 back to storage with other nibble, then IR via 0x1E
    busWrite(16'h0000, 8'h0A, 0, 0, "R2");
    busRead(16'hA000, r, r2);
    chk("R2 storage again", r, 8'h96);
    busWrite(16'hA000, 8'h01, 1, 1, "R11 ramWrEn");
    chk("R11 led held", irLed, 1'b0);
    busWrite(16'h1FFF, 8'h1E, 0, 0, "R2");
    busRead(16'hA000, r, r2);
    chk("R2 nibble E", r, 8'hC0);

    repeat (3) @(negedge clk);
    chk("R9 all pulses seen", expQ.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule